// File: doc/BRIEF.md
# D-PHY Timing Parameter Calculator

This block turns one per-lane link bit rate, given in MHz, into the full set of D-PHY interval counts in byte-clock units. The counts cover the data lane's high-speed entry and exit, the bus turnaround and the clock lane. A one-cycle start pulse captures the rate. A control state machine then feeds four numerators, one at a time, through a single shared restoring divider by 8000. All the other counts follow from those four quotients with small adds and shifts.

A board can replace any count through a per-field override before the counts are packed. The block then presents every count at full width and also packed into four 32-bit control words, with one byte lane per count. A single-cycle done pulse marks that the result is ready. The result holds until the next run completes.

The states are ST_IDLE (waiting), ST_ISSUE (starts the divider on the current numerator), ST_WAIT (captures the quotient when the divider reports it), ST_PACK (applies the overrides and registers the counts) and ST_DONE (pulses done). The transitions are:
- ST_IDLE to ST_ISSUE on start.
- ST_ISSUE to ST_WAIT always.
- ST_WAIT to ST_ISSUE when a quotient arrives and numerators remain.
- ST_WAIT to ST_PACK when the fourth quotient arrives.
- ST_PACK to ST_DONE always.
- ST_DONE to ST_IDLE always.

Top module: `dphy_timing_calc`

## Requirements
- R1: After reset, done_o is 0 and every field and every word reads 0.
- R2: Field 0 (lpx) equals floor(60*rate/8000) + 1.
- R3: Field 1 (hs_prepare) equals floor((80*rate+4000)/8000). Field 2 (hs_zero) equals floor((170*rate+10000)/8000) + 1 - hs_prepare. Field 3 (hs_trail) equals hs_prepare + 1.
- R4: Field 4 (ta_go) is 4*lpx-2. Field 5 (ta_sure) is lpx+2. Field 6 (ta_get) is 4*lpx. Field 7 (hs_exit) is 2*lpx+1. Field 8 (hs_sync) is always 1.
- R5: Field 9 (clk_prepare) equals floor(70*rate/8000). Field 10 (clk_post) is clk_prepare+8. Field 11 (clk_trail) equals clk_prepare. Field 12 (clk_zero) is 4*clk_trail. Field 13 (clk_exit) is 2*clk_trail.
- R6: Word 0 carries lpx, hs_prepare, hs_zero and hs_trail in bits [7:0], [15:8], [23:16] and [31:24]. Word 1 carries ta_go, ta_sure, ta_get and hs_exit in the same four byte lanes.
- R7: Word 2 has bits [7:0] zero, hs_sync in [15:8], clk_zero in [23:16] and clk_trail in [31:24]. Word 3 has clk_prepare in [7:0], clk_post in [15:8], clk_exit in [23:16] and bits [31:24] zero.
- R8: Field i occupies field_o[16*i+15:16*i] at full 16-bit width. Only its low 8 bits are placed in a word.
- R9: When ovr_en_i[i] is 1 at packing time, field i and its word byte take ovr_val_i[16*i+15:16*i] in place of the computed value.
- R10: done_o is high for exactly one cycle, in the cycle after the 109th rising edge following the edge that captured start. Fields and words stay unchanged after that until the next completion.
- R11: A start pulse while a calculation is in progress is ignored. The result and its timing are those of the run already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; rate_i is captured with it |
| rate_i | input | 16 | Per-lane bit rate in MHz |
| ovr_en_i | input | 14 | Per-field override enable |
| ovr_val_i | input | 224 | Override values, 16 bits per field |
| field_o | output | 224 | All fourteen counts, 16 bits each |
| word0_o | output | 32 | Data-lane HS entry word |
| word1_o | output | 32 | Turnaround and HS exit word |
| word2_o | output | 32 | HS sync and clock zero/trail word |
| word3_o | output | 32 | Clock prepare/post/exit word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each division takes 27 edges: one to issue, 25 iterations and one to capture. Four divisions plus the packing edge place done 109 edges after the capturing edge. The bench counts rising edges from the start edge and samples at falling edges. It requires done to appear exactly at count 109 and to be low at the next sample. It also checks every field and word at the done sample. Runs that inject a second start midway must show the same 109-edge timing and the first rate's results.

// File: rtl/dphy_tcalc_pkg.sv
package dphy_tcalc_pkg;
    localparam int NFIELD   = 14;
    localparam int BW       = 8;

    localparam int IX_LPX      = 0;
    localparam int IX_HS_PREP  = 1;
    localparam int IX_HS_ZERO  = 2;
    localparam int IX_HS_TRAIL = 3;
    localparam int IX_TA_GO    = 4;
    localparam int IX_TA_SURE  = 5;
    localparam int IX_TA_GET   = 6;
    localparam int IX_HS_EXIT  = 7;
    localparam int IX_HS_SYNC  = 8;
    localparam int IX_CK_PREP  = 9;
    localparam int IX_CK_POST  = 10;
    localparam int IX_CK_TRAIL = 11;
    localparam int IX_CK_ZERO  = 12;
    localparam int IX_CK_EXIT  = 13;

    localparam int DIVISOR  = 8000;
    localparam int K_LPX    = 60;
    localparam int K_PREP   = 80;
    localparam int OFF_PREP = 4000;
    localparam int K_ZERO   = 170;
    localparam int OFF_ZERO = 10000;
    localparam int K_CLK    = 70;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_PACK,
        ST_DONE
    } calc_state_e;
endpackage

// File: rtl/tcalc_divider.sv
module tcalc_divider #(
    parameter int DW   = 25,
    parameter int DIVR = 8000
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          go_i,
    input  logic [DW-1:0] num_i,
    output logic          vld_o,
    output logic [DW-1:0] quo_o
);
    localparam int VW = $clog2(DIVR + 1);
    localparam int CW = $clog2(DW + 1);
    localparam logic [VW:0] DIV_EXT = (VW+1)'(DIVR);

    logic [VW-1:0] rem_q;
    logic [DW-1:0] quo_q;
    logic [DW-1:0] num_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          vld_q;
    logic [VW:0]   shifted;
    logic [VW:0]   trial;
    logic          fits;

    always_comb begin
        shifted = {rem_q, quo_q[DW-1]};
        fits    = (shifted >= DIV_EXT);
        trial   = shifted - DIV_EXT;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q  <= '0;
            quo_q  <= '0;
            num_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (go_i && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= num_i;
                num_q  <= num_i;
                cnt_q  <= CW'(DW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (fits) begin
                    rem_q <= trial[VW-1:0];
                    quo_q <= {quo_q[DW-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[VW-1:0];
                    quo_q <= {quo_q[DW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    vld_q  <= 1'b1;
                end
            end
        end
    end

    assign vld_o = vld_q;
    assign quo_o = quo_q;

    logic [2*DW-1:0] prod_w;
    logic [2*DW-1:0] numw_w;
    always_comb begin
        prod_w = (2*DW)'(quo_q) * (2*DW)'(DIVR);
        numw_w = (2*DW)'(num_q);
    end

    // R2: a reported quotient is the exact floor of the captured dividend
    p_div_exact_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_q |-> ((prod_w <= numw_w) && ((numw_w - prod_w) < (2*DW)'(DIVR))));

    // R2: partial remainder never reaches the divisor
    p_rem_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_q |-> (rem_q < VW'(DIVR)));
endmodule

// File: rtl/tcalc_fields.sv
module tcalc_fields
    import dphy_tcalc_pkg::*;
#(
    parameter int DW = 25,
    parameter int FW = 16
) (
    input  logic [DW-1:0]        q_lpx_i,
    input  logic [DW-1:0]        q_prep_i,
    input  logic [DW-1:0]        q_zero_i,
    input  logic [DW-1:0]        q_clk_i,
    input  logic [NFIELD-1:0]    ovr_en_i,
    input  logic [NFIELD*FW-1:0] ovr_val_i,
    output logic [NFIELD*FW-1:0] fld_o
);
    logic [FW-1:0] raw [NFIELD];
    logic [FW-1:0] lpx, prep, ckp;

    always_comb begin
        lpx  = FW'(q_lpx_i + DW'(1));
        prep = FW'(q_prep_i);
        ckp  = FW'(q_clk_i);
        raw[IX_LPX]      = lpx;
        raw[IX_HS_PREP]  = prep;
        raw[IX_HS_ZERO]  = FW'(q_zero_i + DW'(1)) - prep;
        raw[IX_HS_TRAIL] = prep + FW'(1);
        raw[IX_TA_GO]    = (lpx << 2) - FW'(2);
        raw[IX_TA_SURE]  = lpx + FW'(2);
        raw[IX_TA_GET]   = lpx << 2;
        raw[IX_HS_EXIT]  = (lpx << 1) + FW'(1);
        raw[IX_HS_SYNC]  = FW'(1);
        raw[IX_CK_PREP]  = ckp;
        raw[IX_CK_POST]  = ckp + FW'(8);
        raw[IX_CK_TRAIL] = ckp;
        raw[IX_CK_ZERO]  = ckp << 2;
        raw[IX_CK_EXIT]  = ckp << 1;
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_ovr
        assign fld_o[g*FW +: FW] = ovr_en_i[g] ? ovr_val_i[g*FW +: FW] : raw[g];
    end
endmodule

// File: rtl/tcalc_pack.sv
module tcalc_pack
    import dphy_tcalc_pkg::*;
(
    input  logic [NFIELD*BW-1:0] byte_i,
    output logic [31:0]          word0_o,
    output logic [31:0]          word1_o,
    output logic [31:0]          word2_o,
    output logic [31:0]          word3_o
);
    function automatic logic [BW-1:0] fb(input logic [NFIELD*BW-1:0] v, input int ix);
        return v[ix*BW +: BW];
    endfunction

    always_comb begin
        word0_o = {fb(byte_i, IX_HS_TRAIL), fb(byte_i, IX_HS_ZERO),
                   fb(byte_i, IX_HS_PREP),  fb(byte_i, IX_LPX)};
        word1_o = {fb(byte_i, IX_HS_EXIT),  fb(byte_i, IX_TA_GET),
                   fb(byte_i, IX_TA_SURE),  fb(byte_i, IX_TA_GO)};
        word2_o = {fb(byte_i, IX_CK_TRAIL), fb(byte_i, IX_CK_ZERO),
                   fb(byte_i, IX_HS_SYNC),  8'h00};
        word3_o = {8'h00,                   fb(byte_i, IX_CK_EXIT),
                   fb(byte_i, IX_CK_POST),  fb(byte_i, IX_CK_PREP)};
    end
endmodule

// File: rtl/dphy_timing_calc.sv
module dphy_timing_calc
    import dphy_tcalc_pkg::*;
#(
    parameter int RW = 16,
    parameter int FW = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [RW-1:0]        rate_i,
    input  logic [NFIELD-1:0]    ovr_en_i,
    input  logic [NFIELD*FW-1:0] ovr_val_i,
    output logic [NFIELD*FW-1:0] field_o,
    output logic [31:0]          word0_o,
    output logic [31:0]          word1_o,
    output logic [31:0]          word2_o,
    output logic [31:0]          word3_o,
    output logic                 done_o
);
    localparam int DW = RW + 9;
    localparam int NQ = 4;
    localparam int IW = $clog2(NQ);

    calc_state_e     state_q, state_d;
    logic [RW-1:0]   rate_q;
    logic [IW-1:0]   idx_q;
    logic [DW-1:0]   quo_q [NQ];
    logic [NFIELD*FW-1:0] fld_q;
    logic [NFIELD*FW-1:0] fld_new;
    logic [NFIELD*BW-1:0] fld_bytes;
    logic [DW-1:0]   numer;
    logic            div_go;
    logic            div_vld;
    logic [DW-1:0]   div_quo;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (div_vld) state_d = (idx_q == IW'(NQ-1)) ? ST_PACK : ST_ISSUE;
            ST_PACK:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        div_go = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_ISSUE: div_go = 1'b1;
            ST_DONE:  done_o = 1'b1;
            default:  ;
        endcase
    end

    // numerator selection
    always_comb begin
        unique case (idx_q)
            2'd0:    numer = DW'(rate_q) * DW'(K_LPX);
            2'd1:    numer = DW'(rate_q) * DW'(K_PREP) + DW'(OFF_PREP);
            2'd2:    numer = DW'(rate_q) * DW'(K_ZERO) + DW'(OFF_ZERO);
            default: numer = DW'(rate_q) * DW'(K_CLK);
        endcase
    end

    // datapath registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rate_q <= '0;
            idx_q  <= '0;
            fld_q  <= '0;
            for (int i = 0; i < NQ; i++) quo_q[i] <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                rate_q <= rate_i;
                idx_q  <= '0;
            end
            if (state_q == ST_WAIT && div_vld) begin
                quo_q[idx_q] <= div_quo;
                idx_q        <= idx_q + IW'(1);
            end
            if (state_q == ST_PACK) fld_q <= fld_new;
        end
    end

    tcalc_divider #(.DW(DW), .DIVR(DIVISOR)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (div_go),
        .num_i  (numer),
        .vld_o  (div_vld),
        .quo_o  (div_quo)
    );

    tcalc_fields #(.DW(DW), .FW(FW)) u_fields (
        .q_lpx_i   (quo_q[0]),
        .q_prep_i  (quo_q[1]),
        .q_zero_i  (quo_q[2]),
        .q_clk_i   (quo_q[3]),
        .ovr_en_i  (ovr_en_i),
        .ovr_val_i (ovr_val_i),
        .fld_o     (fld_new)
    );

    for (genvar g = 0; g < NFIELD; g++) begin : g_bytes
        assign fld_bytes[g*BW +: BW] = fld_q[g*FW +: BW];
    end

    tcalc_pack u_pack (
        .byte_i  (fld_bytes),
        .word0_o (word0_o),
        .word1_o (word1_o),
        .word2_o (word2_o),
        .word3_o (word3_o)
    );

    assign field_o = fld_q;

    // R10: done lasts one cycle
    p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R10: results change only on the packing edge
    p_fields_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_PACK) |=> $stable(field_o));

    // R11: the captured rate is left alone while a run is in progress
    p_rate_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) |=> $stable(rate_q));

    // R11: a quotient only arrives while waiting for it
    p_vld_in_wait_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_vld |-> (state_q == ST_WAIT));
endmodule

// File: tb/dphy_timing_calc_bench.sv
module dphy_timing_calc_bench;
    import dphy_tcalc_pkg::*;

    localparam int FW  = 16;
    localparam int LAT = 4 * (16 + 9 + 2) + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [15:0]          rate = '0;
    logic [NFIELD-1:0]    ovr_en = '0;
    logic [NFIELD*FW-1:0] ovr_val = '0;
    logic [NFIELD*FW-1:0] field;
    logic [31:0]          w0, w1, w2, w3;
    logic                 done;

    int total = 0;
    int bad = 0;
    int exp_f [NFIELD];

    always #2 clk = ~clk;

    dphy_timing_calc u_dphy_timing_calc (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_i(rate),
        .ovr_en_i(ovr_en), .ovr_val_i(ovr_val), .field_o(field),
        .word0_o(w0), .word1_o(w1), .word2_o(w2), .word3_o(w3), .done_o(done)
    );

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    task automatic model(input int r);
        int lp, pr, ck;
        lp = (60 * r) / 8000 + 1;
        pr = (80 * r + 4000) / 8000;
        ck = (70 * r) / 8000;
        exp_f[0]  = lp;
        exp_f[1]  = pr;
        exp_f[2]  = (170 * r + 10000) / 8000 + 1 - pr;
        exp_f[3]  = pr + 1;
        exp_f[4]  = 4 * lp - 2;
        exp_f[5]  = lp + 2;
        exp_f[6]  = 4 * lp;
        exp_f[7]  = 2 * lp + 1;
        exp_f[8]  = 1;
        exp_f[9]  = ck;
        exp_f[10] = ck + 8;
        exp_f[11] = ck;
        exp_f[12] = 4 * ck;
        exp_f[13] = 2 * ck;
        for (int i = 0; i < NFIELD; i++)
            if (ovr_en[i]) exp_f[i] = int'(ovr_val[i*FW +: FW]);
    endtask

    function automatic string freq(input int i);
        if (ovr_en[i]) return "R9";
        if (i == 0) return "R2";
        if (i <= 3) return "R3";
        if (i <= 8) return "R4";
        return "R5";
    endfunction

    function automatic int b(input int i);
        return exp_f[i] & 255;
    endfunction

    task automatic check_outputs();
        int e0, e1, e2, e3;
        for (int i = 0; i < NFIELD; i++)
            chk(freq(i), int'(field[i*FW +: FW]), exp_f[i] & 16'hFFFF);
        e0 = (b(3) << 24) | (b(2) << 16) | (b(1) << 8) | b(0);
        e1 = (b(7) << 24) | (b(6) << 16) | (b(5) << 8) | b(4);
        e2 = (b(11) << 24) | (b(12) << 16) | (b(8) << 8);
        e3 = (b(13) << 16) | (b(10) << 8) | b(9);
        chk(ovr_en != 0 ? "R8" : "R6", int'(w0), e0);
        chk("R6", int'(w1), e1);
        chk("R7", int'(w2), e2);
        chk("R7", int'(w3), e3);
    endtask

    // intr < 0: no second start; otherwise a start with rate intr mid-run
    task automatic run(input int r, input int intr);
        int cnt;
        logic [NFIELD*FW-1:0] held;
        model(r);
        @(negedge clk);
        start = 1'b1;
        rate  = 16'(r);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (cnt < 300) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (done) break;
            if (intr >= 0 && cnt == 20) begin start = 1'b1; rate = 16'(intr); end
            if (cnt == 21) start = 1'b0;
        end
        chk(intr >= 0 ? "R11" : "R10", cnt, LAT);
        check_outputs();
        held = field;
        @(negedge clk);
        chk("R10", int'(done), 0);
        chk("R10", int'(field == held), 1);
    endtask

    initial begin
        #(4 * 190000);
        bad++;
        total++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        chk("R1", int'(done), 0);
        chk("R1", int'(field != 0), 0);
        chk("R1", int'(w0 | w1 | w2 | w3), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(done), 0);
        chk("R1", int'(field != 0), 0);

        // corner rates around rounding thresholds
        run(0, -1);
        run(49, -1);
        run(50, -1);
        run(133, -1);
        run(134, -1);
        run(7999, -1);
        run(8000, -1);
        run(65535, -1);

        // R11: start during a run
        run(1500, 40000);
        run(65535, 3);

        // R9 / R8: overrides, with values wider than one byte
        ovr_en = '0;
        ovr_en[0]  = 1'b1;
        ovr_en[8]  = 1'b1;
        ovr_en[13] = 1'b1;
        ovr_val[0*FW +: FW]  = 16'h01A5;
        ovr_val[8*FW +: FW]  = 16'h0000;
        ovr_val[13*FW +: FW] = 16'h3C7E;
        run(2500, -1);
        ovr_en = '1;
        for (int i = 0; i < NFIELD; i++) ovr_val[i*FW +: FW] = 16'(16'h0111 * (i + 1));
        run(900, -1);
        ovr_en = '0;

        // near-exhaustive sweep over the rate range
        for (int k = 0; k < 1075; k++) run(k * 61, -1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule